// File: doc/BRIEF.md
# Periodic Battery Load-Test Scheduler

This block decides when a backup cell is put under a test load and keeps a latched battery-warning flag. An external comparator reports whether the loaded cell sits below its trip voltage. A presence detector reports whether a cell is attached at all. A supply-good flag says whether main power is within tolerance. A slow timebase tick clocks every interval, and each interval is a parameter counted in ticks.

After main power becomes good, the block waits a recovery delay and then runs a test at once. It closes the load switch for a fixed window. If the comparator shows below-trip in any cycle of that window, the warning is latched. With the warning clear, tests repeat at a long regular period. With the warning set, they repeat at a shorter period so that a battery swap is seen quickly.

The warning is sticky. A passing test clears it only after a proper swap (the cell absent for at least a minimum detach time) or when the test is the first one after power-up. While main power is failed, all testing stops and the load is never applied. A window cut short by a power failure records no result.

Top module: `battTestSched`

## Requirements
- R1: When supplyGood rises, the first load window starts after REC_TICKS ticks, and every load window holds loadEn high for exactly LOAD_TICKS ticks.
- R2: While the warning is clear, the next load window starts REG_TICKS ticks after the previous window ends.
- R3: If battLow is 1 in any single clock cycle of a load window, at the end of that window the warning becomes active: warnN = 0 and warnDrive = 1.
- R4: While the warning is active, the next load window starts WARN_TICKS ticks after the previous window ends.
- R5: An active warning stays active through a passing test unless R6 or R7 applies.
- R6: battPresent going low for at least DETACH_TICKS ticks and then high again clears the warning at the end of the next passing test. An absence shorter than that has no effect.
- R7: A passing test that is the first test after supplyGood rises clears the warning.
- R8: While supplyGood is 0, loadEn is 0 and no tests are scheduled. A window interrupted by a supply failure leaves the warning unchanged.
- R9: After reset, loadEn = 0, warnN = 1 and warnDrive = 0.
- R10: warnN is always the inverse of warnDrive (active-low open-drain warning with its drive enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe; all intervals count these |
| supplyGood | input | 1 | Main supply within tolerance |
| battLow | input | 1 | Comparator: loaded cell below trip point |
| battPresent | input | 1 | A cell is attached |
| loadEn | output | 1 | Closes the test resistor across the cell |
| warnN | output | 1 | Battery warning, active low (open-drain level) |
| warnDrive | output | 1 | Pull-down enable for the warning pin, high when warning active |

## Verification
A wrong phase or a bad counter limit shows up at loadEn as a window that starts or ends at the wrong tick. The bench catches this at the first power-up test, within a few ticks. A corrupted warning flag or swap flag shows on warnN at the end of the next load window, one regular or warning period later at most. A failed gating of the load under supply loss shows on loadEn in the same cycle that supplyGood drops.

// File: rtl/battTestPkg.sv
package battTestPkg;
  typedef enum logic [1:0] {
    PH_OFF     = 2'd0,
    PH_RECOVER = 2'd1,
    PH_LOAD    = 2'd2,
    PH_WAIT    = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   clrCnt;
    logic   sample;
    logic   commit;
    logic   puTest;
    phase_e phase;
  } ctrlStrb_t;
endpackage

// File: rtl/battTestCtrl.sv
module battTestCtrl
  import battTestPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyGood,
  input  logic      phaseDone,
  output ctrlStrb_t strb,
  output logic      loadEn
);
  phase_e state, nextState;
  logic   puTestQ;

  always_comb begin
    nextState = state;
    if (!supplyGood) nextState = PH_OFF;
    else begin
      unique case (state)
        PH_OFF:     nextState = PH_RECOVER;
        PH_RECOVER: if (phaseDone) nextState = PH_LOAD;
        PH_LOAD:    if (phaseDone) nextState = PH_WAIT;
        PH_WAIT:    if (phaseDone) nextState = PH_LOAD;
        default:    nextState = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_OFF;
      puTestQ <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == PH_OFF) puTestQ <= 1'b0;
      else if (state == PH_RECOVER && nextState == PH_LOAD) puTestQ <= 1'b1;
      else if (state == PH_LOAD && nextState != PH_LOAD) puTestQ <= 1'b0;
    end
  end

  always_comb begin
    strb.phase  = state;
    strb.clrCnt = (nextState != state) || (state == PH_OFF);
    strb.sample = (state == PH_LOAD) && supplyGood;
    strb.commit = (state == PH_LOAD) && supplyGood && phaseDone;
    strb.puTest = puTestQ;
  end

  assign loadEn = (state == PH_LOAD) && supplyGood;

  // R8: a failed supply always parks the sequencer
  p_off_on_fail_r8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (state == PH_OFF))
    else $error("p_off_on_fail_r8");

  // R1: recovery delay is followed by a test window
  p_test_after_recover_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_RECOVER && phaseDone && supplyGood) |=> (state == PH_LOAD))
    else $error("p_test_after_recover_r1");
endmodule

// File: rtl/battTestDatapath.sv
module battTestDatapath
  import battTestPkg::*;
#(
  parameter int unsigned REG_TICKS    = 86_400_000,
  parameter int unsigned WARN_TICKS   = 60_000,
  parameter int unsigned LOAD_TICKS   = 1_000,
  parameter int unsigned REC_TICKS    = 150,
  parameter int unsigned DETACH_TICKS = 1_000
)(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      battLow,
  input  logic      battPresent,
  input  ctrlStrb_t strb,
  output logic      phaseDone,
  output logic      warn
);
  localparam int unsigned MAX_A = (REG_TICKS > WARN_TICKS) ? REG_TICKS : WARN_TICKS;
  localparam int unsigned MAX_B = (LOAD_TICKS > REC_TICKS) ? LOAD_TICKS : REC_TICKS;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int ABS_W = $clog2(DETACH_TICKS + 1);
  localparam logic [CNT_W-1:0] REG_END  = CNT_W'(REG_TICKS - 1);
  localparam logic [CNT_W-1:0] WARN_END = CNT_W'(WARN_TICKS - 1);
  localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(LOAD_TICKS - 1);
  localparam logic [CNT_W-1:0] REC_END  = CNT_W'(REC_TICKS - 1);
  localparam logic [ABS_W-1:0] ABS_MAX  = ABS_W'(DETACH_TICKS);

  logic [CNT_W-1:0] cnt, endVal;
  logic [ABS_W-1:0] absCnt;
  logic             failSeen, swapSeen, presentQ, swapOk, testFail;

  always_comb begin
    unique case (strb.phase)
      PH_RECOVER: endVal = REC_END;
      PH_LOAD:    endVal = LOAD_END;
      PH_WAIT:    endVal = warn ? WARN_END : REG_END;
      default:    endVal = '0;
    endcase
  end

  assign phaseDone = tick && (strb.phase != PH_OFF) && (cnt == endVal);
  assign testFail  = failSeen || battLow;
  assign swapOk    = battPresent && !presentQ && (absCnt >= ABS_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      failSeen <= 1'b0;
    end else if (strb.clrCnt) begin
      cnt      <= '0;
      failSeen <= 1'b0;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      if (strb.sample && battLow) failSeen <= 1'b1;
    end
  end

  // absence timer and swap qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      absCnt   <= '0;
      presentQ <= 1'b1;
      swapSeen <= 1'b0;
    end else begin
      presentQ <= battPresent;
      if (battPresent) absCnt <= '0;
      else if (tick && absCnt < ABS_MAX) absCnt <= absCnt + 1'b1;
      if (strb.commit) swapSeen <= 1'b0;
      else if (swapOk) swapSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warn <= 1'b0;
    else if (strb.commit) begin
      if (testFail) warn <= 1'b1;
      else if (!warn || swapSeen || strb.puTest) warn <= 1'b0;
    end
  end

  // R3: a failing test always leaves the warning set
  p_fail_sets_warn_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && testFail) |=> warn)
    else $error("p_fail_sets_warn_r3");

  // R3: the warning only rises at the end of a window
  p_rise_on_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warn) |-> $past(strb.commit))
    else $error("p_rise_on_commit_r3");

  // R5: the warning only falls at the end of a window
  p_fall_on_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(warn) |-> $past(strb.commit))
    else $error("p_fall_on_commit_r5");

  // R2: the phase counter never runs past its limit
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase != PH_OFF) |-> (cnt <= endVal))
    else $error("p_cnt_in_range_r2");
endmodule

// File: rtl/battTestSched.sv
module battTestSched
  import battTestPkg::*;
#(
  parameter int unsigned REG_TICKS    = 86_400_000,
  parameter int unsigned WARN_TICKS   = 60_000,
  parameter int unsigned LOAD_TICKS   = 1_000,
  parameter int unsigned REC_TICKS    = 150,
  parameter int unsigned DETACH_TICKS = 1_000
)(
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic supplyGood,
  input  logic battLow,
  input  logic battPresent,
  output logic loadEn,
  output logic warnN,
  output logic warnDrive
);
  ctrlStrb_t strb;
  logic      phaseDone, warn;

  battTestCtrl uCtrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .phaseDone(phaseDone), .strb(strb), .loadEn(loadEn)
  );

  battTestDatapath #(
    .REG_TICKS(REG_TICKS), .WARN_TICKS(WARN_TICKS), .LOAD_TICKS(LOAD_TICKS),
    .REC_TICKS(REC_TICKS), .DETACH_TICKS(DETACH_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .battLow(battLow),
    .battPresent(battPresent), .strb(strb), .phaseDone(phaseDone), .warn(warn)
  );

  assign warnDrive = warn;
  assign warnN     = ~warn;
endmodule

// File: tb/tb_battTestSched.sv
`timescale 1ns/1ps
module tb_battTestSched;
  localparam int REG = 10, WRN = 4, LD = 2, REC = 3, DET = 3;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic supplyGood = 1'b0, battLow = 1'b0, battPresent = 1'b1;
  logic loadEn, warnN, warnDrive;
  int   checks = 0, failures = 0;
  logic [1:0] div = '0;
  bit   finished = 1'b0;

  battTestSched #(
    .REG_TICKS(REG), .WARN_TICKS(WRN), .LOAD_TICKS(LD),
    .REC_TICKS(REC), .DETACH_TICKS(DET)
  ) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .supplyGood(supplyGood),
    .battLow(battLow), .battPresent(battPresent),
    .loadEn(loadEn), .warnN(warnN), .warnDrive(warnDrive)
  );

  always #2 clk = ~clk;

  // one tick every four cycles, changed on the falling edge
  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkWarn(input string req, input bit expWarn);
    check(warnDrive == expWarn, req, warnDrive, expWarn);
    check(warnN == !expWarn, {req, " R10"}, warnN, !expWarn);
  endtask

  task automatic tickWait(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic waitLoadStart();
    for (int i = 0; i < 400 && !loadEn; i++) @(negedge clk);
  endtask

  task automatic waitLoadEnd();
    waitLoadStart();
    for (int i = 0; i < 400 && loadEn; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check(loadEn == 1'b0, "R9 loadEn", loadEn, 0);
    checkWarn("R9 warn", 1'b0);
  endtask

  task automatic testPowerUpAndRegular();
    tickWait(1);
    supplyGood = 1'b1;
    tickWait(REC - 1);
    check(loadEn == 1'b0, "R1 before recovery end", loadEn, 0);
    tickWait(1);
    check(loadEn == 1'b1, "R1 window start", loadEn, 1);
    tickWait(LD - 1);
    check(loadEn == 1'b1, "R1 window held", loadEn, 1);
    tickWait(1);
    check(loadEn == 1'b0, "R1 window end", loadEn, 0);
    checkWarn("R2 pass keeps clear", 1'b0);
    tickWait(REG - 1);
    check(loadEn == 1'b0, "R2 before period", loadEn, 0);
    tickWait(1);
    check(loadEn == 1'b1, "R2 period start", loadEn, 1);
  endtask

  task automatic testFailAndSticky();
    // inside a window: one-cycle below-trip pulse
    tickWait(1);
    battLow = 1'b1;
    @(negedge clk);
    battLow = 1'b0;
    checkWarn("R3 not before window end", 1'b0);
    tickWait(1);
    checkWarn("R3 pulse latched", 1'b1);
    tickWait(WRN - 1);
    check(loadEn == 1'b0, "R4 before warn period", loadEn, 0);
    tickWait(1);
    check(loadEn == 1'b1, "R4 warn period start", loadEn, 1);
    tickWait(LD);
    checkWarn("R5 pass without swap keeps warning", 1'b1);
  endtask

  task automatic testShortSwap();
    battPresent = 1'b0;
    tickWait(DET - 1);
    battPresent = 1'b1;
    waitLoadEnd();
    checkWarn("R6 short absence ignored", 1'b1);
    waitLoadEnd();
    checkWarn("R6 short absence ignored later", 1'b1);
  endtask

  task automatic testGoodSwap();
    battPresent = 1'b0;
    tickWait(DET + 1);
    battPresent = 1'b1;
    waitLoadEnd();
    checkWarn("R6 qualified swap clears", 1'b0);
    tickWait(REG - 1);
    check(loadEn == 1'b0, "R2 regular resumes before", loadEn, 0);
    tickWait(1);
    check(loadEn == 1'b1, "R2 regular resumes", loadEn, 1);
    waitLoadEnd();
  endtask

  task automatic testPowerCycleClears();
    waitLoadStart();
    battLow = 1'b1;
    waitLoadEnd();
    battLow = 1'b0;
    checkWarn("R3 held low all window", 1'b1);
    supplyGood = 1'b0;
    #1;
    check(loadEn == 1'b0, "R8 load off at failure", loadEn, 0);
    for (int i = 0; i < 2 * WRN; i++) begin
      tickWait(1);
      check(loadEn == 1'b0, "R8 suspended", loadEn, 0);
    end
    checkWarn("R8 warning kept while off", 1'b1);
    supplyGood = 1'b1;
    tickWait(REC);
    check(loadEn == 1'b1, "R1 test at power-up", loadEn, 1);
    tickWait(LD);
    checkWarn("R7 power-up pass clears", 1'b0);
  endtask

  task automatic testAbort();
    waitLoadStart();
    battLow = 1'b1;
    @(negedge clk);
    supplyGood = 1'b0;
    #1;
    check(loadEn == 1'b0, "R8 abort drops load", loadEn, 0);
    battLow = 1'b0;
    tickWait(3);
    checkWarn("R8 aborted window not recorded", 1'b0);
    supplyGood = 1'b1;
    waitLoadEnd();
    checkWarn("R8 clean power-up test", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testPowerUpAndRegular();
    testFailAndSticky();
    testShortSwap();
    testGoodSwap();
    testPowerCycleClears();
    testAbort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule